// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel TFT panel, plus the column and row index of the pixel being shown. It runs on the pixel clock. Each line goes through four phases: sync, back porch, active, front porch. Each frame goes through the same four phases counted in lines, and the vertical counter advances once per completed line.

Software programs the timing through a plain write port: a control word at address 0 and three timing words at addresses 1 to 3. The timing words are held in shadow registers. While the raster is running, a new set is copied into the working set only at the end of a frame, so a frame never mixes old and new values. While the raster is stopped, the copy happens on every cycle. Most intervals are written biased by minus one. The line width is written in 16-pixel units. Several fields are split across two words.

Top module: `lrt_raster_top`

## Requirements
- R1: A line consists of hsync for HS pixels, then back porch for HB, then active for HA, then front porch for HF, and then the next line begins. Timing word 0 holds the following fields. Bits [15:10] hold HS−1 (low 6 bits). Bits [23:16] hold HF−1 (low 8 bits). Bits [31:24] hold HB−1 (low 8 bits). Bits [9:4] hold the low 6 bits of HA/16−1.
- R2: The high parts of the horizontal fields are placed as follows. Bit 6 of HA/16−1 is timing word 0 bit 3, which allows a width of up to 2048. Bits [9:8] of HF−1 are timing word 2 bits [1:0]. Bits [9:8] of HB−1 are timing word 2 bits [5:4]. Bits [9:6] of HS−1 are timing word 2 bits [30:27].
- R3: A frame consists of vsync for VS lines, back porch for VB lines, active for VA lines, and front porch for VF lines. Timing word 1 bits [15:10] hold VS−1. Bits [9:0] hold the low bits of VA−1, and bit 10 of VA−1 is timing word 2 bit 26. Bits [23:16] hold VF and bits [31:24] hold VB, both unbiased. A porch of zero lines is skipped.
- R4: de is active only in a cycle that is in both the horizontal active phase and the vertical active phase.
- R5: While de is active, pix_x counts 0 to HA−1 along the line and pix_y counts 0 to VA−1 down the frame. Both read 0 whenever de is inactive.
- R6: The sync and enable outputs are active high by default. Timing word 2 bit 20 inverts vsync, bit 21 inverts hsync and bit 23 inverts de.
- R7: pclk_inv follows timing word 2 bit 22. sync_fall is 1 only when timing word 2 bit 25 (edge control) and bit 24 (falling edge) are both set.
- R8: Control word bit 0 enables the raster. When it is 0, hsync, vsync and de sit at their inactive levels and pix_x and pix_y read 0. Setting the bit again restarts output at the first hsync cycle of the first vsync line.
- R9: A timing word written while the raster runs takes effect at the first cycle of the next frame. A timing word written while the raster is stopped takes effect when the raster is enabled.
- R10: After reset the raster is stopped, all words are zero, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Word select: 0 control, 1 to 3 timing words 0 to 2 |
| cfg_wdata | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pclk_inv | output | 1 | Selects the inverted pixel clock sampling edge |
| sync_fall | output | 1 | Syncs launched on the falling pixel clock edge |
| pix_x | output | 11 | Active column index |
| pix_y | output | 11 | Active row index |

## Verification
Four patterns are checked against an arithmetic model of line and frame position, cycle by cycle.

- A small, non-inverted setup with a zero vertical back porch shows whether phases are ordered correctly and whether a zero porch is skipped.
- A second setup with a zero vertical front porch and every inversion bit set separates polarity faults from counting faults.
- A wide setup with large values puts ones into every split high field, so a misplaced high bit shifts a visible edge.
- A write made in the middle of a frame, followed by a stop and a restart, shows whether new timing waits for the frame boundary and whether restart returns to the first pixel.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam int LRT_CW = 12;            // holds lengths up to 2048
  localparam int LRT_PW = LRT_CW - 1;    // pixel index width

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } lrt_phase_e;

  typedef struct packed {
    logic [LRT_CW-1:0] hsw;
    logic [LRT_CW-1:0] hbp;
    logic [LRT_CW-1:0] hact;
    logic [LRT_CW-1:0] hfp;
    logic [LRT_CW-1:0] vsw;
    logic [LRT_CW-1:0] vbp;
    logic [LRT_CW-1:0] vact;
    logic [LRT_CW-1:0] vfp;
    logic              inv_v;
    logic              inv_h;
    logic              inv_pclk;
    logic              inv_de;
    logic              sync_fall;
  } lrt_timing_t;
endpackage

// File: rtl/lrt_cfg_decode.sv
module lrt_cfg_decode
  import lrt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word0,
  input  logic [DW-1:0] word1,
  input  logic [DW-1:0] word2,
  output lrt_timing_t   tm
);
  localparam int UNITS_W = 8;  // 7-bit unit field plus carry
  localparam int UNIT_SH = 4;  // 16-pixel granularity

  logic [UNITS_W-1:0] h_units;

  always_comb begin
    h_units = UNITS_W'({word0[3], word0[9:4]}) + UNITS_W'(1);

    tm           = '0;
    tm.hact      = LRT_CW'({h_units, {UNIT_SH{1'b0}}});
    tm.hsw       = LRT_CW'({word2[30:27], word0[15:10]}) + LRT_CW'(1);
    tm.hfp       = LRT_CW'({word2[1:0], word0[23:16]}) + LRT_CW'(1);
    tm.hbp       = LRT_CW'({word2[5:4], word0[31:24]}) + LRT_CW'(1);
    tm.vact      = LRT_CW'({word2[26], word1[9:0]}) + LRT_CW'(1);
    tm.vsw       = LRT_CW'(word1[15:10]) + LRT_CW'(1);
    tm.vfp       = LRT_CW'(word1[23:16]);
    tm.vbp       = LRT_CW'(word1[31:24]);
    tm.inv_v     = word2[20];
    tm.inv_h     = word2[21];
    tm.inv_pclk  = word2[22];
    tm.inv_de    = word2[23];
    tm.sync_fall = word2[25] & word2[24];
  end
endmodule

// File: rtl/lrt_phase_seq.sv
module lrt_phase_seq
  import lrt_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_back,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_front,
  output lrt_phase_e   phase,
  output logic [W-1:0] cnt,
  output logic         at_end
);
  logic [W-1:0] cur_len;
  logic         last_cyc;
  lrt_phase_e   nxt_phase;

  always_comb begin
    unique case (phase)
      PH_SYNC:  cur_len = len_sync;
      PH_BACK:  cur_len = len_back;
      PH_ACT:   cur_len = len_act;
      default:  cur_len = len_front;
    endcase
  end

  assign last_cyc = (cnt == cur_len - W'(1));

  // zero-length porches are stepped over
  always_comb begin
    unique case (phase)
      PH_SYNC:  nxt_phase = (len_back  != '0) ? PH_BACK  : PH_ACT;
      PH_BACK:  nxt_phase = PH_ACT;
      PH_ACT:   nxt_phase = (len_front != '0) ? PH_FRONT : PH_SYNC;
      default:  nxt_phase = PH_SYNC;
    endcase
  end

  assign at_end = last_cyc &&
                  ((phase == PH_FRONT) || (phase == PH_ACT && len_front == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (clear) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (last_cyc) begin
        phase <= nxt_phase;
        cnt   <= '0;
      end else begin
        cnt   <= cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/lrt_raster_top.sv
module lrt_raster_top
  import lrt_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              pclk_inv,
  output logic              sync_fall,
  output logic [LRT_PW-1:0] pix_x,
  output logic [LRT_PW-1:0] pix_y
);
  localparam int NWORDS = 3;
  localparam logic [AW-1:0] A_CTRL = AW'(0);

  logic [DW-1:0] sh_word  [NWORDS];
  logic [DW-1:0] cur_word [NWORDS];
  logic          en_q;
  logic          frame_end;
  lrt_timing_t   tm;

  lrt_phase_e        h_ph, v_ph;
  logic [LRT_CW-1:0] h_cnt, v_cnt;
  logic              h_end, v_end;
  logic              hs_act, vs_act, de_act;

  // control word acts at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= 1'b0;
    else if (cfg_we && cfg_addr == A_CTRL)  en_q <= cfg_wdata[0];
  end

  assign frame_end = en_q && h_end && v_end;

  // shadow and working copies of each timing word
  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_word[gi]  <= '0;
        cur_word[gi] <= '0;
      end else begin
        if (cfg_we && cfg_addr == AW'(gi + 1)) sh_word[gi] <= cfg_wdata;
        if (!en_q || frame_end)                cur_word[gi] <= sh_word[gi];
      end
    end
  end

  lrt_cfg_decode #(.DW(DW)) u_dec (
    .word0 (cur_word[0]),
    .word1 (cur_word[1]),
    .word2 (cur_word[2]),
    .tm    (tm)
  );

  lrt_phase_seq #(.W(LRT_CW)) u_hseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!en_q),
    .step      (en_q),
    .len_sync  (tm.hsw),
    .len_back  (tm.hbp),
    .len_act   (tm.hact),
    .len_front (tm.hfp),
    .phase     (h_ph),
    .cnt       (h_cnt),
    .at_end    (h_end)
  );

  lrt_phase_seq #(.W(LRT_CW)) u_vseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!en_q),
    .step      (en_q && h_end),
    .len_sync  (tm.vsw),
    .len_back  (tm.vbp),
    .len_act   (tm.vact),
    .len_front (tm.vfp),
    .phase     (v_ph),
    .cnt       (v_cnt),
    .at_end    (v_end)
  );

  assign hs_act = en_q && (h_ph == PH_SYNC);
  assign vs_act = en_q && (v_ph == PH_SYNC);
  assign de_act = en_q && (h_ph == PH_ACT) && (v_ph == PH_ACT);

  assign hsync     = hs_act ^ tm.inv_h;
  assign vsync     = vs_act ^ tm.inv_v;
  assign de        = de_act ^ tm.inv_de;
  assign pclk_inv  = tm.inv_pclk;
  assign sync_fall = tm.sync_fall;
  assign pix_x     = de_act ? h_cnt[LRT_PW-1:0] : '0;
  assign pix_y     = de_act ? v_cnt[LRT_PW-1:0] : '0;
endmodule

// File: rtl/lrt_raster_chk.sv
module lrt_raster_chk
  import lrt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              frame_end,
  input logic [95:0]       cur_all,
  input logic              hs_act,
  input logic              vs_act,
  input logic              de_act,
  input logic [LRT_PW-1:0] pix_x,
  input logic [LRT_PW-1:0] pix_y,
  input logic [LRT_CW-1:0] h_len,
  input logic [LRT_CW-1:0] v_len
);
  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> (!hs_act && !vs_act)); // R4

  AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> (LRT_CW'(pix_x) < h_len)); // R5

  AST_Y_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> (LRT_CW'(pix_y) < v_len)); // R5

  AST_X_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (de_act && pix_x != '0) |->
      ($past(de_act) && (LRT_CW'($past(pix_x)) + LRT_CW'(1) == LRT_CW'(pix_x)))); // R5

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !frame_end) |=> $stable(cur_all)); // R9

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!en_q || (hs_act && vs_act))); // R3
endmodule

bind lrt_raster_top lrt_raster_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .frame_end (frame_end),
  .cur_all   ({cur_word[0], cur_word[1], cur_word[2]}),
  .hs_act    (hs_act),
  .vs_act    (vs_act),
  .de_act    (de_act),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .h_len     (tm.hact),
  .v_len     (tm.vact)
);

// File: tb/tb_lrt_raster_top.sv
module tb_lrt_raster_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hsync, vsync, de, pclk_inv, sync_fall;
  logic [10:0] pix_x, pix_y;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // model configuration
  int c_hsw, c_hbp, c_ha, c_hfp, c_vsw, c_vbp, c_va, c_vfp;
  int c_ih, c_iv, c_ide, c_ipc, c_sctl, c_sfall;
  int e_hs, e_vs, e_de, e_x, e_y;

  always #10 clk = ~clk;  // 50 MHz

  lrt_raster_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
    .pclk_inv(pclk_inv), .sync_fall(sync_fall), .pix_x(pix_x), .pix_y(pix_y)
  );

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (time %0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc0();
    int hu = c_ha / 16 - 1;
    int s = c_hsw - 1, f = c_hfp - 1, b = c_hbp - 1;
    return {b[7:0], f[7:0], s[5:0], hu[5:0], hu[6], 3'b000};
  endfunction

  function automatic logic [31:0] enc1();
    int s = c_vsw - 1, a = c_va - 1;
    return {c_vbp[7:0], c_vfp[7:0], s[5:0], a[9:0]};
  endfunction

  function automatic logic [31:0] enc2();
    int s = c_hsw - 1, a = c_va - 1, f = c_hfp - 1, b = c_hbp - 1;
    return {1'b0, s[9:6], a[10], c_sctl[0], c_sfall[0], c_ide[0], c_ipc[0],
            c_ih[0], c_iv[0], 14'd0, b[9:8], 2'b00, f[9:8]};
  endfunction

  task automatic model(input int t);
    int L = c_hsw + c_hbp + c_ha + c_hfp;
    int F = c_vsw + c_vbp + c_va + c_vfp;
    int xp = t % L;
    int ln = (t / L) % F;
    int ha_on = (xp >= c_hsw + c_hbp) && (xp < c_hsw + c_hbp + c_ha);
    int va_on = (ln >= c_vsw + c_vbp) && (ln < c_vsw + c_vbp + c_va);
    e_hs = (xp < c_hsw);
    e_vs = (ln < c_vsw);
    e_de = ha_on && va_on;
    e_x  = e_de ? xp - c_hsw - c_hbp : 0;
    e_y  = e_de ? ln - c_vsw - c_vbp : 0;
  endtask

  task automatic cmp(input int t, input string th, input string tv, input string td);
    model(t);
    chk(th, int'(hsync), e_hs ^ c_ih, "hsync");
    chk(tv, int'(vsync), e_vs ^ c_iv, "vsync");
    chk(td, int'(de), e_de ^ c_ide, "de");
    chk("R5", int'(pix_x), e_x, "pix_x");
    chk("R5", int'(pix_y), e_y, "pix_y");
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // stop, load all words, start; returns on the first running cycle
  task automatic setup();
    wr(2'd0, 32'd0);
    wr(2'd1, enc0());
    wr(2'd2, enc1());
    wr(2'd3, enc2());
    wr(2'd0, 32'd1);
  endtask

  task automatic set_cfg(input int hsw, hbp, ha, hfp, vsw, vbp, va, vfp,
                         input int inv, ipc, sctl, sfall);
    c_hsw = hsw; c_hbp = hbp; c_ha = ha; c_hfp = hfp;
    c_vsw = vsw; c_vbp = vbp; c_va = va; c_vfp = vfp;
    c_ih = inv; c_iv = inv; c_ide = inv;
    c_ipc = ipc; c_sctl = sctl; c_sfall = sfall;
  endtask

  initial begin
    int off;
    int chg_at;
    #45;
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", int'(hsync), 0, "hsync");
    chk("R10", int'(vsync), 0, "vsync");
    chk("R10", int'(de), 0, "de");
    chk("R10", int'(pclk_inv), 0, "pclk_inv");
    chk("R10", int'(pix_x) + int'(pix_y), 0, "pix");

    // Pattern A: zero vertical back porch, two full frames
    set_cfg(2, 3, 16, 1, 1, 0, 3, 2, 0, 0, 0, 1);
    setup();
    chk("R7", int'(sync_fall), 0, "sync_fall without edge control");
    chk("R7", int'(pclk_inv), 0, "pclk_inv");
    for (int t = 0; t < 2 * 22 * 6; t++) begin
      cmp(t, "R1", "R3", "R4");
      @(negedge clk);
    end

    // Pattern B: zero front porch, all inversions, edge control
    set_cfg(1, 1, 32, 3, 2, 2, 2, 0, 1, 1, 1, 1);
    setup();
    chk("R7", int'(sync_fall), 1, "sync_fall");
    chk("R7", int'(pclk_inv), 1, "pclk_inv");
    for (int t = 0; t < 2 * 37 * 6; t++) begin
      cmp(t, "R6", "R6", "R6");
      @(negedge clk);
    end
    // R8: stopping forces inactive (inverted) levels
    wr(2'd0, 32'd0);
    for (int k = 0; k < 3; k++) begin
      chk("R8", int'(hsync), 1, "hsync idle");
      chk("R8", int'(vsync), 1, "vsync idle");
      chk("R8", int'(de), 1, "de idle");
      chk("R8", int'(pix_x) + int'(pix_y), 0, "pix idle");
      @(negedge clk);
    end

    // Pattern C: every split high field carries ones
    set_cfg(70, 300, 1040, 260, 1, 1, 1100, 0, 0, 0, 0, 0);
    setup();
    for (int t = 0; t < 3 * 1670; t++) begin
      cmp(t, "R2", "R3", "R2");
      @(negedge clk);
    end

    // Pattern A again with a write in the middle of frame 0 (R9),
    // then a restart (R8)
    set_cfg(2, 3, 16, 1, 1, 0, 3, 2, 0, 0, 0, 0);
    setup();
    off = 0;
    chg_at = 22 * 6;
    for (int t = 0; t < chg_at + 25 * 6 + 10; t++) begin
      if (t == 40) begin
        c_hfp = 4;
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = enc0();
        c_hfp = 1;
      end else if (t == 41) begin
        cfg_we = 1'b0;
      end
      if (t == chg_at) begin
        c_hfp = 4;
        off = chg_at;
      end
      cmp(t - off, "R9", "R9", "R9");
      @(negedge clk);
    end
    wr(2'd0, 32'd0);
    chk("R8", int'(hsync), 0, "hsync idle");
    chk("R8", int'(de), 0, "de idle");
    wr(2'd0, 32'd1);
    for (int t = 0; t < 30; t++) begin
      cmp(t, "R8", "R8", "R8");
      @(negedge clk);
    end

    summary_and_end();
  end
endmodule